// File: doc/BRIEF.md
# Sync Input Conditioner with Vertical Setup Delay

This block sits between the external horizontal and vertical sync pins and the internal display timing logic. Both pins pass through a synchronizer chain. A per-pin inversion control then turns each pin into an active-high level, so the logic downstream always sees a rising edge as the start of a sync pulse. The inversion controls serve master and slave timing alike.

Across applications, the phase between the vertical and horizontal pulses is not fixed. To keep vertical processing free of jitter, the block does not act on a vertical leading edge straight away. It holds the edge back for a programmable number of time units. The time unit arrives as a one-cycle tick enable, nominally one tick every 3.84 µs. Once the wait has run out, the block marks the vertical event as armed. It then releases the event on the next horizontal leading edge, as a V-start pulse aligned with the H-edge pulse. Each 4-bit setup value from 0 to 15 gives a delay of that many units.

Top module: `sync_cond_top`

## Requirements
- R1: After a synchronous reset, `h_norm_o`, `h_edge_o` and `v_start_o` are all 0, and no V-start pulse appears until a vertical leading edge has been seen.
- R2: `h_norm_o` equals the value of `h_pin_i` XOR `h_inv_i`. The delay is three clock cycles: a pin value sampled at rising edge k shows at `h_norm_o` after rising edge k+2. With `h_inv_i`=0 the pin is active high, and with 1 it is active low.
- R3: Each 0→1 transition of the normalized H level gives exactly one `h_edge_o` pulse, one cycle wide, in the same cycle that `h_norm_o` first reads 1.
- R4: A vertical leading edge is a 0→1 transition of `v_pin_i` XOR `v_inv_i`. With `v_inv_i`=1, a rising pin starts nothing, and a falling pin starts a vertical event.
- R5: With a setup value N from 1 to 15, a vertical event is released only after N `unit_tick_i` pulses. Only ticks that come after the edge is detected count. Any H edge before the Nth tick gives no V-start.
- R6: With a setup value of 0, the event is armed at once and released on the next H leading edge.
- R7: An armed event gives exactly one `v_start_o` pulse, one cycle wide. It falls in the same cycle as the `h_edge_o` pulse that released it. Later H edges give no further pulse.
- R8: Only one vertical event can wait at a time. A new vertical leading edge during the countdown reloads the count from the current setup value, and the two edges together give a single V-start.
- R9: H edges and ticks that arrive while no vertical event is waiting have no effect. They give no V-start, and ticks are not stored toward a later event.
- R10: The setup value is captured at the vertical leading edge. Changing `vsetup_i` during the countdown does not change the delay of the event already waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| h_pin_i | input | 1 | Raw horizontal sync pin |
| v_pin_i | input | 1 | Raw vertical sync pin |
| h_inv_i | input | 1 | 1 inverts the horizontal pin |
| v_inv_i | input | 1 | 1 inverts the vertical pin |
| vsetup_i | input | 4 | Vertical setup delay, in time units (0..15) |
| unit_tick_i | input | 1 | One-cycle tick per time unit |
| h_norm_o | output | 1 | Normalized, synchronized horizontal level |
| h_edge_o | output | 1 | One-cycle pulse on each H leading edge |
| v_start_o | output | 1 | One-cycle H-aligned vertical start pulse |

## Verification
If the countdown state is corrupted, the fault shows at the ports on the first H edge that follows: `v_start_o` fires one H line early or late, or fires twice. The directed scenarios therefore send a single H pulse after each tick and count V-start pulses per window. A broken edge detector or polarity path shows within three cycles on `h_norm_o`, or as a missing or doubled `h_edge_o` count. A V-start that drifts away from its H edge is caught in every cycle by a monitor that pairs the two outputs.

// File: rtl/sync_cond_pkg.sv
package sync_cond_pkg;

  localparam int unsigned SETUP_W_DEF = 4;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic [1:0] {
    VS_IDLE  = 2'd0,
    VS_COUNT = 2'd1,
    VS_ARMED = 2'd2
  } vs_state_t;

endpackage

// File: rtl/sync_pin_cond.sv
module sync_pin_cond #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic inv_i,
  output logic lvl_o,
  output logic edge_o,
  output logic edge_next_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              norm_d;
  logic              lvl_q;
  logic              edge_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("sync_pin_cond needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[LAST-1:0], pin_i};
    end
  end

  // polarity applied after synchronization, edge taken on corrected level
  assign norm_d      = sync_q[LAST] ^ inv_i;
  assign edge_next_o = norm_d & ~lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      lvl_q  <= norm_d;
      edge_q <= edge_next_o;
    end
  end

  assign lvl_o  = lvl_q;
  assign edge_o = edge_q;

  AST_EDGE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    edge_q |=> !edge_q); // R3
  AST_EDGE_WITH_LEVEL: assert property (@(posedge clk) disable iff (rst)
    edge_q |-> lvl_q); // R3
  AST_EDGE_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(edge_q) |-> !$past(lvl_q)); // R3

endmodule

// File: rtl/vsetup_delay.sv
module vsetup_delay
  import sync_cond_pkg::*;
#(
  parameter int unsigned SETUP_W = SETUP_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               v_edge_i,
  input  logic               h_edge_next_i,
  input  logic               tick_i,
  input  logic [SETUP_W-1:0] setup_i,
  output logic               v_start_o
);

  localparam logic [SETUP_W-1:0] CNT_ONE  = SETUP_W'(1);
  localparam logic [SETUP_W-1:0] CNT_ZERO = '0;

  vs_state_t          st_q;
  logic [SETUP_W-1:0] cnt_q;
  logic               vst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= VS_IDLE;
      cnt_q <= CNT_ZERO;
      vst_q <= 1'b0;
    end else begin
      // release uses the state before any reload in this cycle
      vst_q <= (st_q == VS_ARMED) && h_edge_next_i;
      if (v_edge_i) begin
        cnt_q <= setup_i;
        st_q  <= (setup_i == CNT_ZERO) ? VS_ARMED : VS_COUNT;
      end else begin
        case (st_q)
          VS_COUNT: begin
            if (tick_i) begin
              cnt_q <= cnt_q - CNT_ONE;
              if (cnt_q == CNT_ONE) st_q <= VS_ARMED;
            end
          end
          VS_ARMED: begin
            if (h_edge_next_i) st_q <= VS_IDLE;
          end
          default: begin
            st_q <= VS_IDLE;
          end
        endcase
      end
    end
  end

  assign v_start_o = vst_q;

  AST_LOAD_ON_VEDGE: assert property (@(posedge clk) disable iff (rst)
    v_edge_i |=> (cnt_q == $past(setup_i)) && (st_q != VS_IDLE)); // R10
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
    (st_q == VS_COUNT && tick_i && !v_edge_i) |=> (cnt_q == $past(cnt_q) - CNT_ONE)); // R5
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == VS_COUNT && !tick_i && !v_edge_i) |=> (st_q == VS_COUNT) && $stable(cnt_q)); // R5
  AST_ZERO_ARMS: assert property (@(posedge clk) disable iff (rst)
    (v_edge_i && setup_i == CNT_ZERO) |=> (st_q == VS_ARMED)); // R6
  AST_RELEASE_ONCE: assert property (@(posedge clk) disable iff (rst)
    (st_q == VS_ARMED && h_edge_next_i && !v_edge_i) |=> (v_start_o && st_q == VS_IDLE)); // R7
  AST_NO_START_UNARMED: assert property (@(posedge clk) disable iff (rst)
    (st_q != VS_ARMED) |=> !v_start_o); // R9

endmodule

// File: rtl/sync_cond_top.sv
module sync_cond_top
  import sync_cond_pkg::*;
#(
  parameter int unsigned SETUP_W     = SETUP_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               h_pin_i,
  input  logic               v_pin_i,
  input  logic               h_inv_i,
  input  logic               v_inv_i,
  input  logic [SETUP_W-1:0] vsetup_i,
  input  logic               unit_tick_i,
  output logic               h_norm_o,
  output logic               h_edge_o,
  output logic               v_start_o
);

  logic h_lvl, h_edge, h_edge_nx;
  logic v_edge;
  logic unused_v_lvl, unused_v_edge_nx;

  sync_pin_cond #(.STAGES(SYNC_STAGES)) i_h_cond (
    .clk         (clk),
    .rst         (rst),
    .pin_i       (h_pin_i),
    .inv_i       (h_inv_i),
    .lvl_o       (h_lvl),
    .edge_o      (h_edge),
    .edge_next_o (h_edge_nx)
  );

  sync_pin_cond #(.STAGES(SYNC_STAGES)) i_v_cond (
    .clk         (clk),
    .rst         (rst),
    .pin_i       (v_pin_i),
    .inv_i       (v_inv_i),
    .lvl_o       (unused_v_lvl),
    .edge_o      (v_edge),
    .edge_next_o (unused_v_edge_nx)
  );

  vsetup_delay #(.SETUP_W(SETUP_W)) i_vdelay (
    .clk           (clk),
    .rst           (rst),
    .v_edge_i      (v_edge),
    .h_edge_next_i (h_edge_nx),
    .tick_i        (unit_tick_i),
    .setup_i       (vsetup_i),
    .v_start_o     (v_start_o)
  );

  assign h_norm_o = h_lvl;
  assign h_edge_o = h_edge;

  AST_VSTART_ON_HEDGE: assert property (@(posedge clk) disable iff (rst)
    v_start_o |-> h_edge_o); // R7
  AST_VSTART_SINGLE: assert property (@(posedge clk) disable iff (rst)
    v_start_o |=> !v_start_o); // R7

endmodule

// File: tb/test_sync_cond_top.sv
module test_sync_cond_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       h_pin = 1'b0, v_pin = 1'b0, h_inv = 1'b0, v_inv = 1'b0;
  logic [3:0] vsetup = 4'd0;
  logic       tick = 1'b0;
  logic       h_norm, h_edge, v_start;

  int n_checks = 0, n_fail = 0;
  int n_h = 0, n_v = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_cond_top i_sync_cond_top (
    .clk(clk), .rst(rst), .h_pin_i(h_pin), .v_pin_i(v_pin),
    .h_inv_i(h_inv), .v_inv_i(v_inv), .vsetup_i(vsetup),
    .unit_tick_i(tick), .h_norm_o(h_norm), .h_edge_o(h_edge),
    .v_start_o(v_start)
  );

  // pulse counters, read pre-update values at the edge
  always @(posedge clk) begin
    if (!rst) begin
      if (h_edge) n_h++;
      if (v_start) n_v++;
      if (v_start && !h_edge) n_bad++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic h_pulse();
    h_pin = h_inv ? 1'b0 : 1'b1;
    idle(3);
    h_pin = h_inv ? 1'b1 : 1'b0;
    idle(4);
  endtask

  task automatic v_pulse();
    v_pin = v_inv ? 1'b0 : 1'b1;
    idle(3);
    v_pin = v_inv ? 1'b1 : 1'b0;
    idle(5);
  endtask

  task automatic one_tick();
    tick = 1'b1;
    idle(1);
    tick = 1'b0;
    idle(1);
  endtask

  task automatic t_reset();
    chk("R1 h_norm", int'(h_norm), 0);
    chk("R1 h_edge", int'(h_edge), 0);
    chk("R1 v_start", int'(v_start), 0);
  endtask

  task automatic t_h_polarity();
    h_pin = 1'b1;
    idle(2);
    chk("R2 latency not yet", int'(h_norm), 0);
    idle(1);
    chk("R2 latency three cycles", int'(h_norm), 1);
    h_pin = 1'b0;
    idle(4);
    chk("R2 follow low", int'(h_norm), 0);
    h_inv = 1'b1;
    idle(4);
    chk("R2 inverted low pin", int'(h_norm), 1);
    h_pin = 1'b1;
    idle(4);
    chk("R2 inverted high pin", int'(h_norm), 0);
    h_inv = 1'b0;
    h_pin = 1'b0;
    idle(4);
  endtask

  task automatic t_h_edge();
    int h0, v0;
    h0 = n_h; v0 = n_v;
    h_pulse();
    chk("R3 one edge pulse", n_h - h0, 1);
    chk("R9 no v_start without event", n_v - v0, 0);
    h_pin = 1'b1; h_inv = 1'b1;
    idle(4);
    h0 = n_h;
    h_pulse();
    chk("R3 inverted edge pulse", n_h - h0, 1);
    h_pin = 1'b0;
    idle(1);
    h_inv = 1'b0;
    idle(4);
  endtask

  task automatic t_delay();
    int v0;
    for (int i = 0; i < 3; i++) one_tick();
    vsetup = 4'd3;
    v_pulse();
    v0 = n_v;
    h_pulse();
    chk("R9 stale ticks ignored", n_v - v0, 0);
    one_tick(); one_tick();
    h_pulse();
    chk("R5 held after two of three ticks", n_v - v0, 0);
    one_tick();
    h_pulse();
    chk("R5 released after third tick", n_v - v0, 1);
    h_pulse();
    chk("R7 only once", n_v - v0, 1);
  endtask

  task automatic t_zero();
    int v0;
    vsetup = 4'd0;
    v_pulse();
    v0 = n_v;
    h_pulse();
    chk("R6 zero setup next H", n_v - v0, 1);
  endtask

  task automatic t_restart();
    int v0;
    vsetup = 4'd2;
    v_pulse();
    one_tick();
    v_pulse();
    one_tick();
    v0 = n_v;
    h_pulse();
    chk("R8 restart reloads", n_v - v0, 0);
    one_tick();
    h_pulse();
    chk("R8 release after reload", n_v - v0, 1);
    h_pulse();
    chk("R8 single event", n_v - v0, 1);
  endtask

  task automatic t_capture();
    int v0;
    vsetup = 4'd1;
    v_pulse();
    vsetup = 4'd9;
    one_tick();
    v0 = n_v;
    h_pulse();
    chk("R10 setup captured", n_v - v0, 1);
    vsetup = 4'd0;
  endtask

  task automatic t_v_polarity();
    int v0;
    v_inv = 1'b1;
    idle(5);
    h_pulse();
    v_pin = 1'b1;
    idle(6);
    v0 = n_v;
    h_pulse();
    chk("R4 inverted rising pin ignored", n_v - v0, 0);
    v_pin = 1'b0;
    idle(6);
    h_pulse();
    chk("R4 inverted falling pin starts", n_v - v0, 1);
    v_inv = 1'b0;
    idle(6);
    h_pulse();
    chk("R4 no event on restore", n_v - v0, 1);
  endtask

  initial begin
    idle(3);
    t_reset();
    rst = 1'b0;
    idle(2);
    t_reset();
    t_h_polarity();
    t_h_edge();
    t_delay();
    t_zero();
    t_restart();
    t_capture();
    t_v_polarity();
    chk("R7 v_start aligned with h_edge", n_bad, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule